// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits between the digital-correction stage of a pipelined converter core and the parallel output pads. It receives each corrected sample code with a valid strobe, encodes it as straight offset binary or as two's complement, and flags codes that sit at either end of the scale. The formatted word then travels through a parameterised latency pipeline and lands on the output register on the falling clock edge.

A data-ready strobe is derived from the clock and tracks the output word. A companion logic block uses it to capture each word. An active-low enable controls the pad drivers so that several converters can share one bus. While the pads are released, sampling and formatting keep running, so the word on the value lines is always current. A slew-rate mode bit is passed through to the pad cells and has no effect on any logic value.

Top module: `adc_out_formatter`

## Requirements
- R1: With `fmt_sel_i` = 1 at capture, the output word equals the input code unchanged (offset binary).
- R2: With `fmt_sel_i` = 0 at capture, output bit W-1 is the inverse of code bit W-1 and bits W-2..0 equal the code (two's complement).
- R3: `ovr_o` is 1 exactly when the captured code is all zeros or all ones. It is 0 otherwise, whatever the format.
- R4: A code presented with `code_valid_i` = 1 at rising edge k appears on `data_o`/`ovr_o` at the falling edge that follows rising edge k+LAT_G (default LAT_G = 2).
- R5: When no valid word reaches the output stage, `data_o` and `ovr_o` keep their previous values.
- R6: `drdy_o` is 0 from reset until the first valid word is loaded. After that it is 1 during every clock-low phase and 0 during every clock-high phase, so it rises on the same falling edge that updates the data.
- R7: `pad_oe_o` is 1 when `oe_ni` = 0 and 0 when `oe_ni` = 1, with no clock edge in between.
- R8: While `oe_ni` = 1, capture and formatting continue with no sample dropped. When `oe_ni` returns to 0, the newest word is already on `data_o`.
- R9: `slew_o` equals `slew_i`, and `slew_i` has no effect on `data_o`, `ovr_o` or `drdy_o`.
- R10: While `rst_ni` = 0, `data_o`, `ovr_o` and `drdy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; capture on rising edge, output on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | W | Corrected code from the converter core |
| code_valid_i | input | 1 | Code is valid this cycle |
| fmt_sel_i | input | 1 | 1 = offset binary, 0 = two's complement |
| oe_ni | input | 1 | Active-low pad output enable |
| slew_i | input | 1 | Pad slew-rate mode (1 = limited current) |
| data_o | output | W | Output word value to the pad drivers |
| ovr_o | output | 1 | Out-of-range flag value |
| drdy_o | output | 1 | Data-ready strobe value |
| pad_oe_o | output | 1 | Drive enable for all output pads (0 = high impedance) |
| slew_o | output | 1 | Slew-rate mode to the pad cells |

## Verification
Every code is swept in both formats. This covers the four extremes where a design that flags after encoding would set the overrange flag on the wrong codes once two's complement is selected. The output is sampled in both clock phases, so a pipeline that is one stage short or long, or that updates on the rising edge, shows up as a word mismatch in the low phase. The valid stream has gaps and the enable toggles in the middle of the stream. A design that lets the output drift during gaps, or that stalls or drops words while the pads are released, produces wrong words after re-enable. Data-ready is watched from reset, so a strobe that runs before the first word fails.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;
endpackage

// File: rtl/adc_code_encoder.sv
module adc_code_encoder
  import adc_fmt_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] code_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] data_o,
  output logic         ovr_o
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    data_o = code_i;
    if (fmt_i == FMT_TWOS) data_o[MSB] = ~code_i[MSB];
  end

  // flag on the raw code so format select cannot move it
  assign ovr_o = (&code_i) | ~(|code_i);
endmodule

// File: rtl/adc_word_pipe.sv
module adc_word_pipe #(
  parameter int unsigned W     = 12,
  parameter int unsigned LAT_G = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  input  logic         ovr_i,
  output logic [W-1:0] head_data_o,
  output logic         tail_vld_o,
  output logic [W-1:0] tail_data_o,
  output logic         tail_ovr_o
);
  localparam int unsigned STAGES = LAT_G + 1;
  localparam int unsigned LAST   = STAGES - 1;

  logic [W-1:0]      dat_q [STAGES];
  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] ovr_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q[s] <= '0;
          vld_q[s] <= 1'b0;
          ovr_q[s] <= 1'b0;
        end else begin
          dat_q[s] <= data_i;
          vld_q[s] <= vld_i;
          ovr_q[s] <= ovr_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q[s] <= '0;
          vld_q[s] <= 1'b0;
          ovr_q[s] <= 1'b0;
        end else begin
          dat_q[s] <= dat_q[s-1];
          vld_q[s] <= vld_q[s-1];
          ovr_q[s] <= ovr_q[s-1];
        end
      end
    end
  end

  assign head_data_o = dat_q[0];
  assign tail_vld_o  = vld_q[LAST];
  assign tail_data_o = dat_q[LAST];
  assign tail_ovr_o  = ovr_q[LAST];
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  input  logic         ovr_i,
  input  logic         oe_ni,
  output logic [W-1:0] data_o,
  output logic         ovr_o,
  output logic         drdy_o,
  output logic         pad_oe_o
);
  logic [W-1:0] data_q;
  logic         ovr_q;
  logic         armed_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (vld_i) begin
      data_q  <= data_i;
      ovr_q   <= ovr_i;
      armed_q <= 1'b1;
    end
  end

  // clock image: high in the low phase that follows each output update
  assign drdy_o   = armed_q & ~clk_i;
  assign pad_oe_o = ~oe_ni;
  assign data_o   = data_q;
  assign ovr_o    = ovr_q;

  assert_hold_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(data_q) && $stable(ovr_q)));

  assert_armed_sticky_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adc_fmt_pkg::*;
#(
  parameter int unsigned W     = 12,
  parameter int unsigned LAT_G = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  input  logic         code_valid_i,
  input  logic         fmt_sel_i,
  input  logic         oe_ni,
  input  logic         slew_i,
  output logic [W-1:0] data_o,
  output logic         ovr_o,
  output logic         drdy_o,
  output logic         pad_oe_o,
  output logic         slew_o
);
  localparam int unsigned LOW = W - 2;

  logic [W-1:0] enc_data;
  logic         enc_ovr;
  logic [W-1:0] head_data;
  logic         tail_vld;
  logic [W-1:0] tail_data;
  logic         tail_ovr;

  adc_code_encoder #(.W(W)) u_enc (
    .code_i (code_i),
    .fmt_i  (fmt_e'(fmt_sel_i)),
    .data_o (enc_data),
    .ovr_o  (enc_ovr)
  );

  adc_word_pipe #(.W(W), .LAT_G(LAT_G)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (code_valid_i),
    .data_i      (enc_data),
    .ovr_i       (enc_ovr),
    .head_data_o (head_data),
    .tail_vld_o  (tail_vld),
    .tail_data_o (tail_data),
    .tail_ovr_o  (tail_ovr)
  );

  adc_out_stage #(.W(W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (tail_vld),
    .data_i   (tail_data),
    .ovr_i    (tail_ovr),
    .oe_ni    (oe_ni),
    .data_o   (data_o),
    .ovr_o    (ovr_o),
    .drdy_o   (drdy_o),
    .pad_oe_o (pad_oe_o)
  );

  assign slew_o = slew_i;

  assert_low_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i |=> (head_data[LOW:0] == $past(code_i[LOW:0])));

  assert_ovr_extreme_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> ((&data_o[LOW:0]) || !(|data_o[LOW:0])));
endmodule

// File: tb/tb_adc_out_formatter.sv
module tb_adc_out_formatter;
  localparam int W     = 12;
  localparam int LAT   = 2;
  localparam int LAG   = LAT + 2;
  localparam int NCODE = 1 << W;
  localparam int TOTAL = 2 * NCODE;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] code_i = '0;
  logic         code_valid_i = 1'b0;
  logic         fmt_sel_i = 1'b0;
  logic         oe_ni = 1'b0;
  logic         slew_i = 1'b0;
  logic [W-1:0] data_o;
  logic         ovr_o, drdy_o, pad_oe_o, slew_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_out_formatter #(.W(W), .LAT_G(LAT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i), .code_valid_i(code_valid_i),
    .fmt_sel_i(fmt_sel_i), .oe_ni(oe_ni), .slew_i(slew_i), .data_o(data_o),
    .ovr_o(ovr_o), .drdy_o(drdy_o), .pad_oe_o(pad_oe_o), .slew_o(slew_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  bit           hv [LAG];
  logic [W-1:0] hd [LAG];
  bit           ho [LAG];
  bit           hf [LAG];

  initial begin
    logic [W-1:0] exp_d;
    bit           exp_o, exp_f, exp_arm;
    int           cnt, drain;
    exp_d = '0; exp_o = 0; exp_f = 0; exp_arm = 0; cnt = 0; drain = 0;
    for (int k = 0; k < LAG; k++) begin hv[k] = 0; hd[k] = '0; ho[k] = 0; hf[k] = 0; end
    #1 rst_ni = 1'b0;
    #2;
    chk(data_o == '0, "R10 data", data_o, 0);
    chk(ovr_o == 1'b0, "R10 ovr", ovr_o, 0);
    chk(drdy_o == 1'b0, "R10 drdy", drdy_o, 0);
    #9 rst_ni = 1'b1;
    for (int i = 0; i < 20000 && drain <= LAG + 1; i++) begin
      bit           nv, nf;
      logic [W-1:0] nc;
      @(posedge clk_i); #2;
      if (hv[LAG-1]) begin
        exp_d = hd[LAG-1]; exp_o = ho[LAG-1]; exp_f = hf[LAG-1]; exp_arm = 1;
      end
      chk(data_o == exp_d, exp_f ? (oe_ni ? "R1 R8 data" : "R1 data")
                                 : (oe_ni ? "R2 R8 data" : "R2 data"), data_o, exp_d);
      chk(ovr_o == exp_o, oe_ni ? "R3 R8 ovr" : "R3 ovr", ovr_o, exp_o);
      chk(drdy_o == 1'b0, "R6 drdy high phase", drdy_o, 0);
      chk(slew_o == slew_i, "R9 slew", slew_o, slew_i);
      for (int k = LAG - 1; k > 0; k--) begin
        hv[k] = hv[k-1]; hd[k] = hd[k-1]; ho[k] = ho[k-1]; hf[k] = hf[k-1];
      end
      nv = (cnt < TOTAL) && (i >= 6) && (i % 5 != 3);
      nc = W'(cnt);
      nf = ((cnt / NCODE) % 2) == 1;
      hv[0] = nv;
      hd[0] = nf ? nc : (nc ^ (W'(1) << (W - 1)));
      ho[0] = (nc == '0) || (nc == '1);
      hf[0] = nf;
      code_i       = nv ? nc : W'(i * 37);
      code_valid_i = nv;
      fmt_sel_i    = nv ? nf : i[0];
      oe_ni        = ((i / 37) % 3) == 2;
      slew_i       = i[3] ^ i[6];
      if (nv) cnt++;
      if (cnt >= TOTAL) drain++;
      #1;
      chk(pad_oe_o == !oe_ni, "R7 pad enable", pad_oe_o, !oe_ni);
      #4;
      chk(drdy_o == (exp_arm | hv[LAG-1]), "R6 drdy low phase", drdy_o, exp_arm | hv[LAG-1]);
      chk(data_o == (hv[LAG-1] ? hd[LAG-1] : exp_d), "R4 R5 falling-edge word",
          data_o, hv[LAG-1] ? hd[LAG-1] : exp_d);
    end
    chk(cnt == TOTAL, "R8 words issued", cnt, TOTAL);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule